// File: doc/BRIEF.md
# Circular List Add/Remove Engine

This block runs one of four operations on a circular list of 16-bit entries kept in an ordinary byte-addressed memory: push at the head (add-top), push at the tail (add-bottom), pop from the head (remove-top) or pop from the tail (remove-bottom). A client applies a list base address, an operation code and, for adds, a 16-bit value, then pulses `start`. The engine reads the list header through its own synchronous memory port, checks for overflow or underflow, updates the used count and the relevant index byte, moves the entry, and pulses `done`. At that point it also presents a condition code and, for removes, the entry that was taken off the list.

The list sits at an even base address. The header halfword comes first. Its upper byte is the slot capacity and its lower byte is the occupancy. A head index byte and a tail index byte follow, then the slot area. Head and tail update asymmetrically. Add-bottom writes and then advances the tail. Add-top retreats the head and then writes. Remove-bottom retreats the tail and then reads. Remove-top reads and then advances the head. Every index move wraps around the capacity.

The controller is a single state machine with these states: `S_IDLE`, `S_HDR_RD`, `S_HDR_CHK`, `S_IDX_CHK`, `S_IDX_WR`, `S_SLOT_ACC`, `S_SLOT_WAIT` and `S_FINISH`. Its transitions are:
- `S_IDLE`→`S_HDR_RD` on `start`.
- `S_HDR_RD`→`S_HDR_CHK` always.
- `S_HDR_CHK`→`S_FINISH` on rejection, or →`S_IDX_CHK` when the operation is legal.
- `S_IDX_CHK`→`S_IDX_WR`→`S_SLOT_ACC` always.
- `S_SLOT_ACC`→`S_FINISH` for adds, or →`S_SLOT_WAIT` for removes.
- `S_SLOT_WAIT`→`S_FINISH`.
- `S_FINISH`→`S_IDLE`.

Top module: `clist_engine`

## Requirements
- R1: Layout and encodings. The slot capacity is the byte at base and the used count is the byte at base+1; together they form the header halfword, high byte at the lower address. The head index byte is at base+2 and the tail index byte at base+3. Slot i is the halfword at base+4+2*i, high byte first. `op` codes: 2'b00 add-top, 2'b01 add-bottom, 2'b10 remove-top, 2'b11 remove-bottom. `cc` bits are {C,V,G,L} from bit 3 down to bit 0, and C is always 0.
- R2: An add when used >= capacity finishes with `cc` = 4'b0100 (V) and performs no memory write.
- R3: A remove when used = 0 finishes with `cc` = 4'b0100 (V) and performs no memory write.
- R4: Add-bottom stores the value in the slot at the current tail index. It then sets the tail to tail+1, or to 0 when tail+1 reaches the capacity.
- R5: Add-top first sets the head to head-1, or to capacity-1 when head is 0. It then stores the value in the slot at the new head.
- R6: Remove-bottom first moves the tail back with the same wrap as R5. It then returns the slot at the new tail on `rm_data`.
- R7: Remove-top returns the slot at the current head on `rm_data`. It then advances the head with the same wrap as R4.
- R8: A successful add writes used+1 back to the used byte and a successful remove writes used-1; a successful add performs exactly three writes and a remove exactly two.
- R9: A successful remove finishes with `cc` = 4'b0010 (G) when entries remain and 4'b0000 when the list became empty; a successful add finishes with 4'b0000. `rm_data` changes only on a successful remove.
- R10: `done` is high for exactly one cycle per accepted `start`. Count clock edges from the edge that samples `start`. `done` is high after edge 2 on rejection, after edge 5 for an add and after edge 6 for a remove.
- R11: `start` is ignored while an operation is in progress (through the `done` cycle), and the memory port is idle outside an operation.
- R12: After reset `done`, `mem_req`, `cc` and `rm_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op | input | 2 | Operation code, see R1 |
| base | input | AW | Even byte address of the list header |
| wr_data | input | 16 | Value to add |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access (data in bits 7:0), 0 = halfword |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the read request |
| rm_data | output | 16 | Entry returned by the last successful remove |
| cc | output | 4 | Condition code {C,V,G,L} |
| done | output | 1 | One-cycle completion pulse |

## Verification
Results arrive a fixed number of edges after the edge that samples `start`: two for a rejected operation, five for an add and six for a remove. `cc` and `rm_data` are valid from the `done` cycle onwards. The bench's behavioural model derives that latency from the header contents before the operation begins. It then compares `done` at every falling edge after the start, expecting it high at exactly the predicted count and low at every other count up to eight. `cc`, `rm_data` and the whole list region of memory are compared once that window has closed.

// File: rtl/clist_pkg.sv
package clist_pkg;

    typedef enum logic [1:0] {
        OP_ADD_TOP = 2'b00,
        OP_ADD_BOT = 2'b01,
        OP_REM_TOP = 2'b10,
        OP_REM_BOT = 2'b11
    } clist_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR_RD,
        S_HDR_CHK,
        S_IDX_CHK,
        S_IDX_WR,
        S_SLOT_ACC,
        S_SLOT_WAIT,
        S_FINISH
    } clist_state_e;

    typedef enum logic [2:0] {
        A_HDR,
        A_USED,
        A_TOP,
        A_BOT,
        A_SLOT
    } clist_addr_sel_e;

    localparam int CC_W = 4;
    localparam logic [CC_W-1:0] CC_NONE   = 4'b0000;
    localparam logic [CC_W-1:0] CC_REJECT = 4'b0100;
    localparam logic [CC_W-1:0] CC_MORE   = 4'b0010;

endpackage

// File: rtl/clist_wrap_step.sv
module clist_wrap_step #(
    parameter int IW   = 8,
    parameter bit DOWN = 1'b0
) (
    input  logic [IW-1:0] idx_i,
    input  logic [IW-1:0] slots_i,
    output logic [IW-1:0] idx_o
);

    generate
        if (DOWN) begin : g_dec
            assign idx_o = (idx_i == '0) ? (slots_i - IW'(1)) : (idx_i - IW'(1));
        end else begin : g_inc
            logic [IW:0] sum;
            assign sum   = {1'b0, idx_i} + (IW+1)'(1);
            assign idx_o = (sum >= {1'b0, slots_i}) ? '0 : sum[IW-1:0];
        end
    endgenerate

endmodule

// File: rtl/clist_addr_gen.sv
module clist_addr_gen
    import clist_pkg::*;
#(
    parameter int AW       = 16,
    parameter int IW       = 8,
    parameter int TOP_OFS  = 2,
    parameter int BOT_OFS  = 3,
    parameter int SLOT_OFS = 4
) (
    input  logic [AW-1:0]   base_i,
    input  clist_addr_sel_e sel_i,
    input  logic [IW-1:0]   slot_i,
    output logic [AW-1:0]   addr_o
);

    localparam int PADW = AW - IW - 1;

    logic [AW-1:0] slot_off;
    assign slot_off = {{PADW{1'b0}}, slot_i, 1'b0};

    always_comb begin
        case (sel_i)
            A_HDR:   addr_o = base_i;
            A_USED:  addr_o = base_i + AW'(1);
            A_TOP:   addr_o = base_i + AW'(TOP_OFS);
            A_BOT:   addr_o = base_i + AW'(BOT_OFS);
            default: addr_o = base_i + AW'(SLOT_OFS) + slot_off;
        endcase
    end

endmodule

// File: rtl/clist_engine.sv
module clist_engine
    import clist_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int IW       = 8,
    parameter int TOP_OFS  = 2,
    parameter int BOT_OFS  = 3,
    parameter int SLOT_OFS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] wr_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rm_data,
    output logic [3:0]    cc,
    output logic          done
);

    localparam int BPAD = DW - IW;

    clist_state_e    state_q, state_d;
    logic [1:0]      op_q;
    logic [AW-1:0]   base_q;
    logic [DW-1:0]   wdata_q;
    logic [IW-1:0]   slots_q;
    logic [IW-1:0]   used_q;
    logic [IW-1:0]   idx_q;
    logic [DW-1:0]   rm_data_q;
    logic [3:0]      cc_q;

    logic            is_rem, is_bot, keep_old;
    logic            hdr_ok;
    logic [IW-1:0]   used_nxt;
    logic [IW-1:0]   idx_inc, idx_dec;
    logic [IW-1:0]   slot_idx, idx_new;
    clist_addr_sel_e addr_sel;

    assign is_rem   = op_q[1];
    assign is_bot   = op_q[0];
    // Tail add and head remove touch the slot at the old index.
    assign keep_old = is_bot ^ is_rem;
    assign used_nxt = is_rem ? (used_q - IW'(1)) : (used_q + IW'(1));
    assign hdr_ok   = is_rem ? (mem_rdata[IW-1:0] != '0)
                             : (mem_rdata[IW-1:0] < mem_rdata[DW-1:IW]);

    clist_wrap_step #(.IW(IW), .DOWN(1'b0)) u_inc (
        .idx_i   (idx_q),
        .slots_i (slots_q),
        .idx_o   (idx_inc)
    );

    clist_wrap_step #(.IW(IW), .DOWN(1'b1)) u_dec (
        .idx_i   (idx_q),
        .slots_i (slots_q),
        .idx_o   (idx_dec)
    );

    assign slot_idx = keep_old ? idx_q   : idx_dec;
    assign idx_new  = keep_old ? idx_inc : idx_dec;

    clist_addr_gen #(
        .AW       (AW),
        .IW       (IW),
        .TOP_OFS  (TOP_OFS),
        .BOT_OFS  (BOT_OFS),
        .SLOT_OFS (SLOT_OFS)
    ) u_addr (
        .base_i (base_q),
        .sel_i  (addr_sel),
        .slot_i (slot_idx),
        .addr_o (mem_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_HDR_RD;
            S_HDR_RD:    state_d = S_HDR_CHK;
            S_HDR_CHK:   state_d = hdr_ok ? S_IDX_CHK : S_FINISH;
            S_IDX_CHK:   state_d = S_IDX_WR;
            S_IDX_WR:    state_d = S_SLOT_ACC;
            S_SLOT_ACC:  state_d = is_rem ? S_SLOT_WAIT : S_FINISH;
            S_SLOT_WAIT: state_d = S_FINISH;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            base_q    <= '0;
            wdata_q   <= '0;
            slots_q   <= '0;
            used_q    <= '0;
            idx_q     <= '0;
            rm_data_q <= '0;
            cc_q      <= CC_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        op_q    <= op;
                        base_q  <= base;
                        wdata_q <= wr_data;
                    end
                end
                S_HDR_CHK: begin
                    slots_q <= mem_rdata[DW-1:IW];
                    used_q  <= mem_rdata[IW-1:0];
                    if (!hdr_ok) cc_q <= CC_REJECT;
                end
                S_IDX_CHK: begin
                    idx_q <= mem_rdata[IW-1:0];
                end
                S_SLOT_ACC: begin
                    if (!is_rem) cc_q <= CC_NONE;
                end
                S_SLOT_WAIT: begin
                    rm_data_q <= mem_rdata;
                    cc_q      <= (used_q != IW'(1)) ? CC_MORE : CC_NONE;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_wdata = '0;
        addr_sel  = A_HDR;
        done      = 1'b0;
        unique case (state_q)
            S_HDR_RD: begin
                mem_req = 1'b1;
            end
            S_HDR_CHK: begin
                mem_req  = hdr_ok;
                mem_byte = 1'b1;
                addr_sel = is_bot ? A_BOT : A_TOP;
            end
            S_IDX_CHK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                addr_sel  = A_USED;
                mem_wdata = {{BPAD{1'b0}}, used_nxt};
            end
            S_IDX_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                addr_sel  = is_bot ? A_BOT : A_TOP;
                mem_wdata = {{BPAD{1'b0}}, idx_new};
            end
            S_SLOT_ACC: begin
                mem_req   = 1'b1;
                mem_we    = ~is_rem;
                addr_sel  = A_SLOT;
                mem_wdata = wdata_q;
            end
            S_FINISH: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign rm_data = rm_data_q;
    assign cc      = cc_q;

endmodule

// File: rtl/clist_engine_chk.sv
module clist_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_byte,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    cc,
    input logic          done
);

    logic       busy_q;
    logic       rem_q;
    logic [2:0] wr_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            rem_q    <= 1'b0;
            wr_cnt_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q   <= 1'b1;
                rem_q    <= op[1];
                wr_cnt_q <= '0;
            end
        end else begin
            if (done) busy_q <= 1'b0;
            if (mem_req && mem_we) wr_cnt_q <= wr_cnt_q + 3'd1;
        end
    end

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: a write is always a memory request; halfword writes are aligned
    p_we_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
    p_hw_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_byte) |-> !mem_addr[0]);

    // R2 and R3: a rejected operation leaves memory untouched
    p_reject_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cc[2]) |-> (wr_cnt_q == 3'd0));

    // R8: write count of a successful add or remove
    p_write_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cc[2]) |-> (wr_cnt_q == (rem_q ? 3'd2 : 3'd3)));

    // R9: V and G never reported together, C never set
    p_cc_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!(cc[2] && cc[1]) && !cc[3]));

    // R11: memory port quiet outside an operation
    p_req_in_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mem_req);

    // R11: done only ends an accepted operation
    p_done_in_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

endmodule

bind clist_engine clist_engine_chk #(.AW(AW)) u_clist_engine_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_byte (mem_byte),
    .mem_addr (mem_addr),
    .cc       (cc),
    .done     (done)
);

// File: tb/clist_engine_bench.sv
module clist_engine_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [AW-1:0] base = '0;
    logic [15:0]   wr_data = '0;
    logic          mem_req, mem_we, mem_byte;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic [15:0]   rm_data;
    logic [3:0]    cc;
    logic          done;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [7:0] mem   [0:255];
    logic [7:0] exp_m [0:255];
    logic [15:0] exp_rm = '0;

    always #4 clk = ~clk;

    clist_engine #(.AW(AW)) u_clist_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base(base),
        .wr_data(wr_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rm_data(rm_data), .cc(cc), .done(done)
    );

    // Byte-addressed memory, high byte at the lower address, one-cycle read
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_byte) mem[mem_addr[7:0]] <= mem_wdata[7:0];
                else begin
                    mem[mem_addr[7:0]]         <= mem_wdata[15:8];
                    mem[mem_addr[7:0] + 8'd1]  <= mem_wdata[7:0];
                end
            end else begin
                if (mem_byte) mem_rdata <= {8'h00, mem[mem_addr[7:0]]};
                else mem_rdata <= {mem[mem_addr[7:0]], mem[mem_addr[7:0] + 8'd1]};
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic init_list(input int b, input int slots, input int used,
                             input int top, input int bot);
        mem[b] = 8'(slots);   exp_m[b] = 8'(slots);
        mem[b+1] = 8'(used);  exp_m[b+1] = 8'(used);
        mem[b+2] = 8'(top);   exp_m[b+2] = 8'(top);
        mem[b+3] = 8'(bot);   exp_m[b+3] = 8'(bot);
        for (int i = 0; i < 2*slots; i++) begin
            mem[b+4+i] = 8'(i * 7 + 1);
            exp_m[b+4+i] = 8'(i * 7 + 1);
        end
    endtask

    // Behavioural model of one operation on exp_m
    task automatic model(input logic [1:0] o, input int b, input logic [15:0] d,
                         output logic [3:0] ecc, output int lat);
        int slots = exp_m[b];
        int used  = exp_m[b+1];
        int top   = exp_m[b+2];
        int bot   = exp_m[b+3];
        int idx;
        bit rem = o[1];
        bit btm = o[0];
        if ((!rem && used >= slots) || (rem && used == 0)) begin
            ecc = 4'b0100;
            lat = 2;
        end else if (!rem) begin
            if (btm) begin
                idx = bot;
                exp_m[b+3] = 8'((bot + 1 >= slots) ? 0 : bot + 1);
            end else begin
                top = (top == 0) ? slots - 1 : top - 1;
                exp_m[b+2] = 8'(top);
                idx = top;
            end
            exp_m[b+4+2*idx]   = d[15:8];
            exp_m[b+4+2*idx+1] = d[7:0];
            exp_m[b+1] = 8'(used + 1);
            ecc = 4'b0000;
            lat = 5;
        end else begin
            if (btm) begin
                bot = (bot == 0) ? slots - 1 : bot - 1;
                exp_m[b+3] = 8'(bot);
                idx = bot;
            end else begin
                idx = top;
                exp_m[b+2] = 8'((top + 1 >= slots) ? 0 : top + 1);
            end
            exp_rm = {exp_m[b+4+2*idx], exp_m[b+4+2*idx+1]};
            exp_m[b+1] = 8'(used - 1);
            ecc = (used - 1 != 0) ? 4'b0010 : 4'b0000;
            lat = 6;
        end
    endtask

    task automatic run_op(input logic [1:0] o, input int b, input logic [15:0] d,
                          input bit poke, input string req);
        logic [3:0] ecc;
        int lat;
        int slots = exp_m[b];
        model(o, b, d, ecc, lat);
        @(negedge clk);
        op = o; base = AW'(b); wr_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            @(posedge clk);
            @(negedge clk);
            check(done == (n == lat), {"R10 done timing ", req}, done, (n == lat));
            if (poke && (n == 2 || n == lat)) begin
                start = 1'b1; op = ~o; wr_data = 16'hDEAD;   // R11: must be ignored
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(cc == ecc, {"R9 cc ", req}, cc, ecc);
        check(rm_data == exp_rm, {"R6/R7 rm_data ", req}, rm_data, exp_rm);
        for (int i = 0; i < 4 + 2*slots; i++)
            check(mem[b+i] == exp_m[b+i], {"R1 memory ", req}, mem[b+i], exp_m[b+i]);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            exp_m[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        check(done == 1'b0, "R12 done", done, 0);
        check(mem_req == 1'b0, "R12 mem_req", mem_req, 0);
        check(cc == 4'b0, "R12 cc", cc, 0);
        check(rm_data == 16'h0, "R12 rm_data", rm_data, 0);
        rst_n = 1'b1;

        init_list(8'h40, 4, 0, 0, 0);
        run_op(2'b10, 8'h40, 16'h0000, 1'b0, "R3 remove-top empty");
        run_op(2'b11, 8'h40, 16'h0000, 1'b0, "R3 remove-bottom empty");
        run_op(2'b01, 8'h40, 16'h1111, 1'b0, "R4 add-bottom");
        run_op(2'b01, 8'h40, 16'h2222, 1'b0, "R4 add-bottom second");
        run_op(2'b00, 8'h40, 16'h3333, 1'b0, "R5 add-top wrap from 0");
        run_op(2'b00, 8'h40, 16'h4444, 1'b1, "R11 add-top with busy start");
        run_op(2'b01, 8'h40, 16'h5555, 1'b0, "R2 add-bottom full");
        run_op(2'b00, 8'h40, 16'h6666, 1'b0, "R2 add-top full");
        run_op(2'b10, 8'h40, 16'h0000, 1'b0, "R7 remove-top");
        run_op(2'b11, 8'h40, 16'h0000, 1'b1, "R6 remove-bottom busy start");
        run_op(2'b10, 8'h40, 16'h0000, 1'b0, "R7 remove-top third");
        run_op(2'b11, 8'h40, 16'h0000, 1'b0, "R9 remove-bottom to empty");

        init_list(8'h80, 3, 1, 1, 2);
        run_op(2'b01, 8'h80, 16'hA5A5, 1'b0, "R4 add-bottom wrap at capacity");
        run_op(2'b11, 8'h80, 16'h0000, 1'b0, "R6 remove-bottom wrap from 0");
        run_op(2'b10, 8'h80, 16'h0000, 1'b0, "R8 remove-top used count");
        run_op(2'b10, 8'h80, 16'h0000, 1'b0, "R3 remove after empty");

        init_list(8'hC0, 2, 5, 0, 1);
        run_op(2'b01, 8'hC0, 16'hBEEF, 1'b0, "R2 add with used above capacity");

        init_list(8'hD0, 0, 0, 0, 0);
        run_op(2'b00, 8'hD0, 16'h1234, 1'b0, "R2 add zero capacity");

        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule